// File: doc/BRIEF.md
# UART Transmit Framer

The block turns parallel characters into an asynchronous serial frame on a single transmit line. A one-entry holding stage accepts a character through a valid/ready handshake. A shift sequencer then sends a start bit, the data bits, an optional parity bit and the stop time. Bit timing comes from an external tick that pulses `OVERSAMPLE` times per bit period, which must be an even number. This lets the block produce a stop time of one and a half bits.

The line format comes from a set of static configuration inputs: word length, stop-bit select, parity enable, parity sense and fixed (stick) parity. A break input pulls the line low at once and holds it there. The shift sequencer copies the configuration when it loads a character, so each frame has one consistent format. A transmitter-empty flag tells the system when the line has gone fully quiet.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is 1, `ready_o` is 1 and `tx_empty_o` is 1.
- R2: A frame starts with one 0 bit. The data bits follow, least significant first. `wlen_i` sets the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R3: With `par_en_i`=1 and `par_stick_i`=0, one parity bit follows the data. It makes the count of ones in data plus parity even when `par_even_i`=1, and odd when `par_even_i`=0. With `par_en_i`=0 no parity bit is sent.
- R4: With `par_en_i`=1 and `par_stick_i`=1, the parity bit is a constant: 0 when `par_even_i`=1 and 1 when `par_even_i`=0.
- R5: The stop time is line 1. It lasts 1 bit when `two_stop_i`=0. When `two_stop_i`=1 it lasts 1.5 bits for 5-bit words and 2 bits for longer words.
- R6: `ready_o` is 1 exactly when the holding stage is empty, and a character is taken on a cycle with `valid_i`=1 and `ready_o`=1. A character held at the end of a stop time starts its start bit on the very next tick period, with no idle gap.
- R7: `tx_empty_o` is 1 only when no character is held and the last stop time has completed. It rises in the cycle after the final stop tick.
- R8: While `break_i`=1, `txd_o` is 0 in the same cycle. No new frame starts. A held character stays held and is sent unchanged after `break_i` returns to 0.
- R9: Bit timing advances only on `tick_i`. Each start, data and parity bit lasts `OVERSAMPLE` ticks. With no ticks the line holds its current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampled bit-timing tick |
| data_i | input | DATA_W | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Holding stage empty |
| wlen_i | input | 2 | Word length code |
| two_stop_i | input | 1 | Long stop time select |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Fixed parity enable |
| break_i | input | 1 | Force line low |
| txd_o | output | 1 | Serial line |
| tx_empty_o | output | 1 | Holding stage and shifter both idle |

## Verification
A wrong sequencer state or bit counter shows up on `txd_o` within one bit period. It appears as a misplaced parity slot, a missing or extra data bit, or a wrong stop time, and the bench catches it by sampling every bit at mid-period and timing the stop edge exactly. A fault in the holding stage shows up either as a gap or overlap between back-to-back frames, or as `tx_empty_o` rising one cycle away from the expected stop end. During a break, a lost or corrupted held character shows up in the first frame sent after the release.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } utx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } utx_cfg_t;
endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        wlen_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              par_o
);
  localparam int unsigned MIN_W = DATA_W - 3;

  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < MIN_W) begin : g_fixed
      assign mask[g] = 1'b1;
    end else begin : g_sel
      assign mask[g] = (wlen_i >= 2'(g - MIN_W + 1));
    end
  end

  // stick: constant opposite of the even select
  assign par_o = stick_i ? ~even_i : ((^(data_i & mask)) ^ ~even_i);
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic              pop_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && full_q |=> $stable(data_q)); // R6
  AST_POP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_q); // R6
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              brk_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  input  utx_cfg_t          cfg_i,
  output logic              pop_o,
  output logic              line_o,
  output logic              busy_o
);
  localparam int unsigned MIN_W = DATA_W - 3;
  localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE + 1);
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  utx_state_e        state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q, stop_last, cnt_last;
  logic [BIT_W-1:0]  bits_q;
  utx_cfg_t          cfg_q;
  logic              par_q, par_d, line_q, adv;

  utx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i (data_i),
    .wlen_i (cfg_i.wlen),
    .even_i (cfg_i.par_even),
    .stick_i(cfg_i.par_stick),
    .par_o  (par_d)
  );

  always_comb begin
    if (!cfg_q.two_stop)       stop_last = CNT_W'(OVERSAMPLE - 1);
    else if (cfg_q.wlen == '0) stop_last = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    else                       stop_last = CNT_W'(2 * OVERSAMPLE - 1);
    cnt_last = (state_q == ST_STOP) ? stop_last : CNT_W'(OVERSAMPLE - 1);
  end

  assign adv    = tick_i && (cnt_q == cnt_last);
  assign busy_o = (state_q != ST_IDLE);
  assign pop_o  = avail_i && !brk_i &&
                  ((state_q == ST_IDLE) || ((state_q == ST_STOP) && adv));
  assign line_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      bits_q  <= '0;
      cfg_q   <= '0;
      par_q   <= 1'b0;
      line_q  <= 1'b1;
    end else if (pop_o) begin
      state_q <= ST_START;
      sh_q    <= data_i;
      cfg_q   <= cfg_i;
      par_q   <= par_d;
      cnt_q   <= '0;
      line_q  <= 1'b0;
    end else if (busy_o && tick_i) begin
      cnt_q <= adv ? '0 : cnt_q + CNT_W'(1);
      if (adv) begin
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            line_q  <= sh_q[0];
            sh_q    <= sh_q >> 1;
            bits_q  <= BIT_W'(MIN_W - 1) + BIT_W'(cfg_q.wlen);
          end
          ST_DATA: begin
            if (bits_q != '0) begin
              line_q <= sh_q[0];
              sh_q   <= sh_q >> 1;
              bits_q <= bits_q - BIT_W'(1);
            end else if (cfg_q.par_en) begin
              state_q <= ST_PAR;
              line_q  <= par_q;
            end else begin
              state_q <= ST_STOP;
              line_q  <= 1'b1;
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            line_q  <= 1'b1;
          end
          ST_STOP: begin
            state_q <= ST_IDLE;
            line_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(line_q) && $stable(state_q)); // R9
  AST_NO_START_IN_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && brk_i |=> (state_q == ST_IDLE)); // R8
  AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> line_q); // R5
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_q); // R2
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import utx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [1:0]        wlen_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  input  logic              break_i,
  output logic              txd_o,
  output logic              tx_empty_o
);
  logic              pop, full, line, busy;
  logic [DATA_W-1:0] held;
  utx_cfg_t          cfg;

  assign cfg = '{wlen: wlen_i, two_stop: two_stop_i, par_en: par_en_i,
                 par_even: par_even_i, par_stick: par_stick_i};

  utx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .ready_o(ready_o),
    .pop_i  (pop),
    .full_o (full),
    .data_o (held)
  );

  utx_shift #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .brk_i  (break_i),
    .avail_i(full),
    .data_i (held),
    .cfg_i  (cfg),
    .pop_o  (pop),
    .line_o (line),
    .busy_o (busy)
  );

  assign txd_o      = line & ~break_i;
  assign tx_empty_o = ~full & ~busy;

  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> ready_o); // R7
  AST_EMPTY_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o && !break_i |-> txd_o); // R7
  AST_BREAK_KEEPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i && !ready_o |=> !ready_o); // R8
endmodule

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;
  localparam int OS = 4;
  // vector: {wlen[1:0], two_stop, par_en, par_even, par_stick, data[7:0]}
  localparam logic [13:0] VECS [0:7] = '{
    {6'b11_0_0_0_0, 8'hA5}, {6'b00_0_1_1_0, 8'hF3},
    {6'b01_1_1_0_0, 8'h2C}, {6'b10_0_1_1_1, 8'h7F},
    {6'b11_1_1_0_1, 8'h00}, {6'b00_1_0_0_0, 8'h15},
    {6'b11_0_1_1_0, 8'h81}, {6'b10_1_1_0_0, 8'h5A}
  };

  logic clk = 0, rst_ni = 0, tick = 1, valid = 0, brk = 0;
  logic two_stop = 0, par_en = 0, par_even = 0, par_stick = 0;
  logic [1:0] wlen = 0;
  logic [7:0] data = 0;
  logic txd, ready, empty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_tx_framer #(.OVERSAMPLE(OS), .DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .data_i(data), .valid_i(valid),
    .ready_o(ready), .wlen_i(wlen), .two_stop_i(two_stop), .par_en_i(par_en),
    .par_even_i(par_even), .par_stick_i(par_stick), .break_i(brk),
    .txd_o(txd), .tx_empty_o(empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [5:0] c);
    {wlen, two_stop, par_en, par_even, par_stick} = c;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1; data = d;
    @(negedge clk);
    valid = 0;
  endtask

  // started=1: current negedge is the first one showing the start bit
  task automatic frame(input logic [5:0] c, input logic [7:0] d,
                       input bit started, input bit next_follows);
    logic exp [0:10];
    int nb, n, st, t, ones, w;
    logic p;
    nb = 5 + int'(c[5:4]);
    exp[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      exp[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (c[1]) p = ~c[1] | ~c[0]; else p = 1'b0;
    if (c[0]) p = ~c[1];
    else p = c[1] ? ((ones % 2) == 1) : ((ones % 2) == 0);
    n = 1 + nb;
    if (c[2]) begin exp[n] = p; n++; end
    st = !c[3] ? OS : (c[5:4] == 2'd0 ? OS + OS / 2 : 2 * OS);
    t = OS * n + st;
    if (!started) begin
      w = 0;
      do begin @(negedge clk); w++; end while (txd !== 1'b0 && w < 2000);
    end
    chk("R2 start edge", txd, 0);
    for (int k = 1; k <= t; k++) begin
      @(negedge clk);
      if (k < OS * n && (k % OS) == OS / 2) begin
        if (c[2] && k / OS == n - 1) chk(c[0] ? "R4 stick parity" : "R3 parity", txd, exp[k/OS]);
        else chk("R2 data bit", txd, exp[k/OS]);
      end
      if (k == OS * n) chk("R5 stop begins high", txd, 1);
      if (k == t - 1) begin
        chk("R5 stop still high", txd, 1);
        chk("R7 empty low during stop", empty, 0);
      end
    end
    if (next_follows) chk("R6 back-to-back start", txd, 0);
    else chk("R7 empty after stop", empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 line idle in reset", txd, 1);
    chk("R1 ready in reset", ready, 1);
    chk("R1 empty in reset", empty, 1);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 line idle", txd, 1);
    chk("R1 empty", empty, 1);

    for (int v = 0; v < 8; v++) begin
      set_cfg(VECS[v][13:8]);
      fork
        send(VECS[v][7:0]);
        frame(VECS[v][13:8], VECS[v][7:0], 0, 0);
      join
    end

    // R6: two characters back to back
    set_cfg(6'b11_0_0_0_0);
    fork
      begin
        send(8'h3C);
        send(8'hC3);
        @(negedge clk);
        chk("R6 ready low while held", ready, 0);
      end
      begin
        frame(6'b11_0_0_0_0, 8'h3C, 0, 1);
        frame(6'b11_0_0_0_0, 8'hC3, 1, 0);
      end
    join

    // R8: break mid-character, queued byte survives
    send(8'h11);
    send(8'h96);
    repeat (10) @(negedge clk);
    brk = 1;
    #1 chk("R8 break forces low", txd, 0);
    repeat (60) @(negedge clk);
    chk("R8 line low during break", txd, 0);
    chk("R8 queued byte still held", ready, 0);
    chk("R8 not empty while held", empty, 0);
    brk = 0;
    frame(6'b11_0_0_0_0, 8'h96, 0, 0);

    // R9: no tick, no progress
    tick = 0;
    send(8'hFF);
    repeat (20) @(negedge clk);
    chk("R9 start held without tick", txd, 0);
    chk("R9 busy without tick", empty, 0);
    tick = 1;
    repeat (OS - 1) @(negedge clk);
    chk("R9 start lasts OS ticks", txd, 0);
    @(negedge clk);
    chk("R9 first data bit after OS ticks", txd, 1);
    for (int w = 0; w < 200 && !empty; w++) @(negedge clk);
    chk("R9 frame completes", empty, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule